// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block turns two ordinary push-buttons into a guarded hard-reset source. A hard reset is raised only when both buttons are held down together, without a break, for a multi-second setup time. The setup time is picked by a select pin: 7.5 s or 12.5 s. A brief press of one or both buttons never touches the reset outputs. The same buttons can therefore be wired to a processor's interrupt lines for normal use. A `both_held` status output tells the processor that both buttons are down, well before the reset threshold is reached.

The reset is raised on two outputs at once, one active-low and one active-high. The reset lasts exactly as long as the buttons are held. There is no minimum pulse width and no pulse at power-up. A supply-good qualifier gates everything. While it is low, the buttons are ignored and both outputs stay released. All four asynchronous inputs pass through a two-flop synchroniser.

The controller is a four-state machine:
- `ST_OFF`: the supply is not good.
- `ST_IDLE`: waiting for a joint press.
- `ST_ARMED`: both buttons are held and the timer is running.
- `ST_FIRED`: the reset is asserted.

Its transitions are:
- Any state goes to `ST_OFF` when the supply is not good. This case has priority over all others.
- `ST_OFF` goes to `ST_ARMED` when the supply returns with both buttons down.
- `ST_OFF` goes to `ST_IDLE` when the supply returns otherwise.
- `ST_IDLE` goes to `ST_ARMED` on a joint press.
- `ST_ARMED` goes to `ST_IDLE` on any release.
- `ST_ARMED` goes to `ST_FIRED` when the hold count reaches the selected threshold.
- `ST_FIRED` goes to `ST_IDLE` on any release.

Top module: `dualkey_hold_reset`

## Requirements
- R1: Button inputs are active-low. `rst_out` rises on the (N+3)th rising clock edge after both raw button inputs go low with the supply good, provided both stay low throughout. N is the selected threshold in cycles. No reset occurs unless both buttons are held together.
- R2: With `dly_sel` low, N = CLK_HZ·SHORT_TENTHS/10 cycles (7.5 s by default). With `dly_sel` high, N = CLK_HZ·LONG_TENTHS/10 cycles (12.5 s by default).
- R3: `rst_out_n` is always the inverse of `rst_out`, so the two outputs assert and release on the same edge.
- R4: Once the reset is asserted, raising either button input releases both outputs on the third rising edge after that change.
- R5: After `rst_n` and with no joint press, the outputs are released: `rst_out`=0 and `rst_out_n`=1. No reset pulse appears at power-up, and the pulse width follows the hold time with no minimum.
- R6: While `supply_ok` is low, the buttons are ignored and both outputs are released. The outputs release on the third edge after `supply_ok` falls.
- R7: A joint press shorter than the selected threshold causes no activity on `rst_out` or `rst_out_n`.
- R8: The hold count clears whenever either button is up or the supply is not good. A new joint press times from zero. The count saturates at the long threshold and never wraps.
- R9: The select pin is followed continuously. Switching it during a hold compares the running count against the new threshold without restarting. If the count already exceeds the short threshold, the reset fires on the third edge after `dly_sel` falls.
- R10: `both_held` rises on the third edge after both buttons go low with the supply good. It falls on the third edge after either button rises or the supply drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ Hz |
| rst_n | input | 1 | Asynchronous active-low block reset |
| key0_n | input | 1 | First push-button, active-low, asynchronous |
| key1_n | input | 1 | Second push-button, active-low, asynchronous |
| dly_sel | input | 1 | Setup-time select: 0 = short, 1 = long |
| supply_ok | input | 1 | Supply-good qualifier, high when the supply is valid |
| rst_out_n | output | 1 | Hard reset, active-low |
| rst_out | output | 1 | Hard reset, active-high |
| both_held | output | 1 | Status: both buttons currently held with the supply good |

## Verification
The bench drives joint presses that stop one cycle short of the threshold and one cycle past it, for both select settings. An off-by-one in the counter or the compare would move the reset edge and be reported at the exact sample.

Presses are broken and then resumed. A counter that failed to clear would fire early on the resumed press.

The select is switched from long to short mid-hold. A design that restarted timing on a select change would miss the prompt reset.

The supply is dropped while the reset is asserted, and a long press is made with the supply low. A design that did not gate on supply-good would keep or raise the reset.

// File: rtl/dkr_pkg.sv
package dkr_pkg;

    // Controller states of the long-press reset generator
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // supply not good, everything held released
        ST_IDLE  = 2'd1,   // waiting for a joint press
        ST_ARMED = 2'd2,   // both buttons down, timer running
        ST_FIRED = 2'd3    // reset asserted until a release
    } dkr_state_e;

    // Cycles in a delay given in tenths of a second
    function automatic longint dkr_cycles(input longint hz, input longint tenths);
        return (hz * tenths) / 10;
    endfunction

endpackage

// File: rtl/dkr_sync.sv
module dkr_sync #(
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    // One independent two-flop chain per bit, each with its own idle level
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_async[b];
                stab_q <= meta_q;
            end
        end

        assign q_sync[b] = stab_q;
    end

endmodule

// File: rtl/dkr_hold_timer.sv
module dkr_hold_timer #(
    parameter int              CNT_W   = 8,
    parameter logic [CNT_W-1:0] SHORT_V = 8'd60,
    parameter logic [CNT_W-1:0] LONG_V  = 8'd100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,       // joint press qualified by supply
    input  logic             sel_long,  // live threshold select
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_cur;
    logic             at_cap;

    // Threshold follows the select every cycle; the count is never restarted by it
    assign thr_cur = sel_long ? LONG_V : SHORT_V;
    assign at_cap  = (cnt_q == LONG_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!at_cap) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign done = (cnt_q >= thr_cur);

endmodule

// File: rtl/dkr_fsm.sv
module dkr_fsm
    import dkr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_ok,
    input  logic       pressed,   // both buttons down (synchronised)
    input  logic       done,      // hold count reached threshold
    output dkr_state_e state,
    output logic       fire,
    output logic       held
);

    dkr_state_e state_q;
    dkr_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic; loss of supply overrides every other transition
    always_comb begin
        state_nx = state_q;
        if (!sup_ok) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_nx = pressed ? ST_ARMED : ST_IDLE;
                ST_IDLE:  if (pressed) state_nx = ST_ARMED;
                ST_ARMED: begin
                    if (!pressed)  state_nx = ST_IDLE;
                    else if (done) state_nx = ST_FIRED;
                end
                ST_FIRED: if (!pressed) state_nx = ST_IDLE;
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    // Output decode
    always_comb begin
        fire = 1'b0;
        held = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_IDLE:  ;
            ST_ARMED: held = 1'b1;
            ST_FIRED: begin
                held = 1'b1;
                fire = 1'b1;
            end
            default:  ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/dualkey_hold_reset.sv
module dualkey_hold_reset
    import dkr_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 32_000_000,
    parameter int unsigned SHORT_TENTHS = 75,
    parameter int unsigned LONG_TENTHS  = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key0_n,
    input  logic key1_n,
    input  logic dly_sel,
    input  logic supply_ok,
    output logic rst_out_n,
    output logic rst_out,
    output logic both_held
);

    localparam longint SHORT_CYC = dkr_cycles(longint'(CLK_HZ), longint'(SHORT_TENTHS));
    localparam longint LONG_CYC  = dkr_cycles(longint'(CLK_HZ), longint'(LONG_TENTHS));
    localparam int     CNT_W     = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);

    // Synchronised bit order: {select, supply, key1, key0}; idle levels released / supply bad
    localparam int          SYNC_W   = 4;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 4'b0011;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn;
    logic              k0_s, k1_s, sup_s, sel_s;
    logic              both_s;
    logic              pressed_ok;
    logic [CNT_W-1:0]  hold_cnt;
    logic              hold_done;
    dkr_state_e        ctl_state;
    logic              fire;
    logic              held;

    assign raw_in = {dly_sel, supply_ok, key1_n, key0_n};

    dkr_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn)
    );

    assign k0_s       = syn[0];
    assign k1_s       = syn[1];
    assign sup_s      = syn[2];
    assign sel_s      = syn[3];
    assign both_s     = !k0_s && !k1_s;
    assign pressed_ok = both_s && sup_s;

    dkr_hold_timer #(
        .CNT_W   (CNT_W),
        .SHORT_V (SHORT_V),
        .LONG_V  (LONG_V)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pressed_ok),
        .sel_long (sel_s),
        .cnt      (hold_cnt),
        .done     (hold_done)
    );

    dkr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup_ok  (sup_s),
        .pressed (both_s),
        .done    (hold_done),
        .state   (ctl_state),
        .fire    (fire),
        .held    (held)
    );

    assign rst_out   = fire;
    assign rst_out_n = !fire;
    assign both_held = held;

endmodule

// File: rtl/dkr_checker.sv
module dkr_checker #(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] SHORT_V = 8'd60,
    parameter logic [CNT_W-1:0] LONG_V  = 8'd100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pressed_ok,
    input logic             sup_s,
    input logic             sel_s,
    input logic [CNT_W-1:0] hold_cnt,
    input logic             rst_out,
    input logic             rst_out_n,
    input logic             both_held
);

    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out != rst_out_n);

    p_fire_after_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> ($past(pressed_ok) && $past(hold_cnt) >= SHORT_V));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out && !pressed_ok) |=> !rst_out);

    p_supply_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!rst_out && !both_held));

    p_count_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pressed_ok |=> (hold_cnt == '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= LONG_V);

    p_live_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pressed_ok && !sel_s && hold_cnt >= SHORT_V) |=> rst_out);

    p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pressed_ok |=> both_held);

endmodule

bind dualkey_hold_reset dkr_checker #(
    .CNT_W   (CNT_W),
    .SHORT_V (SHORT_V),
    .LONG_V  (LONG_V)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pressed_ok (pressed_ok),
    .sup_s      (sup_s),
    .sel_s      (sel_s),
    .hold_cnt   (hold_cnt),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n),
    .both_held  (both_held)
);

// File: tb/dualkey_hold_reset_tb_top.sv
`timescale 1ns/1ps
module dualkey_hold_reset_tb_top;

    localparam int CLK_HZ = 8;               // scaled: 60 / 100 cycle thresholds
    localparam int THR_S  = CLK_HZ * 75 / 10;
    localparam int THR_L  = CLK_HZ * 125 / 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key0_n = 1'b1, key1_n = 1'b1, dly_sel = 1'b0, supply_ok = 1'b0;
    logic rst_out_n, rst_out, both_held;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R5";
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dualkey_hold_reset #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .key0_n    (key0_n),
        .key1_n    (key1_n),
        .dly_sel   (dly_sel),
        .supply_ok (supply_ok),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out),
        .both_held (both_held)
    );

    // Behavioural reference: input delay queues plus a run-length integer
    logic q_k0[$], q_k1[$], q_sup[$], q_sel[$];
    int  run_len;
    bit  m_rst, m_held;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_k0 = '{1'b1, 1'b1}; q_k1 = '{1'b1, 1'b1};
            q_sup = '{1'b0, 1'b0}; q_sel = '{1'b0, 1'b0};
            run_len = 0; m_rst = 1'b0; m_held = 1'b0;
        end else begin
            bit p;
            int thr;
            p   = q_sup[0] && !q_k0[0] && !q_k1[0];
            thr = q_sel[0] ? THR_L : THR_S;
            if (!p) begin
                run_len = 0;
                m_rst   = 1'b0;
            end else begin
                if (run_len >= thr) m_rst = 1'b1;
                if (run_len < THR_L) run_len++;
            end
            m_held = p;
            void'(q_k0.pop_front());  q_k0.push_back(key0_n);
            void'(q_k1.pop_front());  q_k1.push_back(key1_n);
            void'(q_sup.pop_front()); q_sup.push_back(supply_ok);
            void'(q_sel.pop_front()); q_sel.push_back(dly_sel);
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(phase, "rst_out vs model", rst_out, m_rst);
            chk("R3", "rst_out_n vs model", rst_out_n, !m_rst);
            chk(phase, "both_held vs model", both_held, m_held);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic press();  key0_n = 1'b0; key1_n = 1'b0; endtask
    task automatic release_all(); key0_n = 1'b1; key1_n = 1'b1; endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        edges(3);
        chk("R5", "reset state rst_out", rst_out, 1'b0);
        chk("R5", "reset state rst_out_n", rst_out_n, 1'b1);
        rst_n = 1'b1;
        supply_ok = 1'b1;
        edges(8);
        chk("R5", "no power-up pulse", rst_out, 1'b0);

        // R7: short joint press, and R1: single-button long press
        phase = "R7";
        press(); edges(THR_S - 5); release_all(); edges(6);
        chk("R7", "short press no reset", rst_out, 1'b0);
        phase = "R1";
        key0_n = 1'b0; edges(THR_L + 20);
        chk("R1", "single button no reset", rst_out, 1'b0);
        release_all(); edges(5);

        // R1/R2/R10: exact edge with short select
        phase = "R1";
        press(); edges(2);
        chk("R10", "held not yet", both_held, 1'b0);
        edges(1);
        chk("R10", "held on 3rd edge", both_held, 1'b1);
        edges(THR_S - 1);
        chk("R1", "not yet at N+2", rst_out, 1'b0);
        edges(1);
        chk("R1", "fires at N+3 short", rst_out, 1'b1);
        chk("R3", "low side active", rst_out_n, 1'b0);
        edges(17);
        chk("R5", "held as long as pressed", rst_out, 1'b1);
        phase = "R4";
        key1_n = 1'b1; edges(2);
        chk("R4", "still active 2 edges", rst_out, 1'b1);
        edges(1);
        chk("R4", "released 3rd edge", rst_out, 1'b0);
        chk("R10", "held drops", both_held, 1'b0);
        key0_n = 1'b1; edges(4);

        // R2: long select
        phase = "R2";
        dly_sel = 1'b1; edges(4);
        press(); edges(THR_L + 2);
        chk("R2", "long not yet at N+2", rst_out, 1'b0);
        edges(1);
        chk("R2", "long fires at N+3", rst_out, 1'b1);
        release_all(); edges(4);

        // R8: interrupted hold restarts
        phase = "R8";
        dly_sel = 1'b0; edges(4);
        press(); edges(THR_S - 10); key0_n = 1'b1; edges(3); key0_n = 1'b0;
        edges(THR_S - 10);
        chk("R8", "restart from zero", rst_out, 1'b0);
        edges(13);
        chk("R8", "fires after full restart", rst_out, 1'b1);
        edges(THR_L + 20);
        chk("R8", "saturated count still firing", rst_out, 1'b1);

        // R6: supply drop while fired, then press with supply low
        phase = "R6";
        supply_ok = 1'b0; edges(2);
        chk("R6", "still active 2 edges", rst_out, 1'b1);
        edges(1);
        chk("R6", "released on supply loss", rst_out, 1'b0);
        edges(THR_L + 10);
        chk("R6", "ignored while supply low", rst_out, 1'b0);
        chk("R6", "status low while supply low", both_held, 1'b0);
        release_all(); supply_ok = 1'b1; edges(4);

        // R9: select change mid-hold
        phase = "R9";
        dly_sel = 1'b1; edges(4);
        press(); edges(THR_S + 20);
        chk("R9", "long select holding", rst_out, 1'b0);
        dly_sel = 1'b0; edges(2);
        chk("R9", "not before select sync", rst_out, 1'b0);
        edges(1);
        chk("R9", "fires on new threshold", rst_out, 1'b1);
        release_all(); edges(5);
        chk("R4", "final release", rst_out, 1'b0);

        finish_run();
    end

endmodule